// File: doc/BRIEF.md
# Serial Voice Memory Fetch Master

This block fetches compressed voice data from an external serial memory on behalf of a speech decoder. It drives three pins: an address clock, a read clock and one data line whose direction changes during a transfer. When the speech engine raises its request, the block puts a 24-bit start address on the data line, most significant bit first, with one bit for each address-clock pulse. It then releases the data line and clocks data bits back in with the read clock. It packs every five bits into one parallel sample for the decoder.

Reads run on without a break. The memory advances its own bit address and the block keeps clocking until the engine drops its request. Both serial clocks come from a programmable divider, so each high and each low phase lasts a chosen number of system cycles. An option input makes the block float the whole bus while no transfer is running: the data driver and the clock drivers are switched off. Without the option, the idle bus is held low.

Top module: `voice_serial_fetch`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) busy, aclk_o, rclk_o and sample_vld are all 0.
- R2: In the address phase the 24 bits of start_addr appear on sd_out most significant bit first, one bit per aclk_o pulse, with sd_oe = 1. Each bit is held for the whole high phase of its pulse, and rclk_o stays 0.
- R3: Each high phase and each low phase of aclk_o and rclk_o lasts N = max(half_cyc, 1) system cycles. The first aclk_o rise comes N clock edges after the edge that accepts the request.
- R4: After the 24th address pulse, sd_oe is 0. rclk_o pulses and sd_in is captured on each rising edge of rclk_o.
- R5: Every five captured bits form one sample, and the first captured bit is bit 4. sample_vld is a one-cycle pulse, set on the edge of the fifth capture. The first pulse comes 57·N edges after the accepting edge.
- R6: Read pulses continue while req stays 1, and successive samples cover successive memory bits. When req is 0 at an edge, the block is idle after that edge: no sample_vld, clocks 0, and a partly assembled sample is dropped.
- R7: While idle with float_idle = 1, sd_oe = 0 and bus_oe = 0. While idle with float_idle = 0, bus_oe = 1, sd_oe = 1, sd_out = 0 and both clocks are 0.
- R8: busy is 1 from the accepting edge until the block returns to idle, and bus_oe is 1 whenever busy is 1.
- R9: aclk_o and rclk_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Read request from the speech engine |
| start_addr | input | 24 | Start bit address, sampled when the request is accepted |
| half_cyc | input | 8 | System cycles per serial clock phase (0 is treated as 1) |
| float_idle | input | 1 | 1 = release all bus drivers while idle |
| sd_in | input | 1 | Data pin input value |
| aclk_o | output | 1 | Address clock pin |
| rclk_o | output | 1 | Read clock pin |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| bus_oe | output | 1 | Output enable for the two clock pins |
| sample | output | 5 | Assembled voice sample |
| sample_vld | output | 1 | One-cycle strobe: sample is new |
| busy | output | 1 | Transfer in progress |

## Verification
All timing is counted from the clock edge that first sees req high. The first address-clock rise is due N edges later, each phase of a pulse lasts N cycles, and the first sample strobe is due 57·N edges later (48·N for the address, 9·N for five reads). Later strobes follow every 10·N edges. The effect of dropping req is due one edge later. The bench drives inputs and samples outputs on falling clock edges, and it keeps a free-running edge counter. Each latency is the difference between the counter value when the request was driven and the counter value when the result is seen, compared against N+1 and 57·N+1. A bench model of the memory records the received address on address-clock rises and supplies bits from an address-dependent function, so the sample values are predicted without reference to the design.

// File: rtl/vsf_pkg.sv
// Package: shared types for the serial voice fetch master.
// Assumes: nothing beyond standard SystemVerilog.
package vsf_pkg;
    typedef enum logic [1:0] {
        VSF_IDLE = 2'd0,
        VSF_ADDR = 2'd1,
        VSF_READ = 2'd2
    } vsf_state_t;
endpackage

// File: rtl/vsf_phase_timer.sv
// Module: serial clock phase generator. While run is high it produces a
// level that holds each value for max(half_cyc,1) system cycles, starting
// low. It flags the cycle before each rising and each falling transition.
// Assumes: half_cyc does not change while run is high.
module vsf_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cyc,
    output logic             phase,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    // Effective phase length: a zero setting behaves as one cycle.
    always_comb begin
        lim  = (half_cyc == '0) ? DIV_W'(1) : half_cyc;
        wrap = (cnt == lim - DIV_W'(1));
    end

    assign rise_p = run & wrap & ~phase;
    assign fall_p = run & wrap &  phase;

    // Count cycles within a phase and toggle the level at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/vsf_addr_shifter.sv
// Module: address serializer. Loads a start address and presents it one
// bit at a time, most significant first. It flags the last bit.
// Assumes: shift is asserted once per address clock pulse.
module vsf_addr_shifter #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int CW = $clog2(ADDR_W);

    logic [ADDR_W-1:0] shreg;
    logic [CW-1:0]     bcnt;

    assign msb  = shreg[ADDR_W-1];
    assign last = (bcnt == CW'(ADDR_W - 1));

    // Load the address, then move one bit towards the output per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (load) begin
            shreg <= load_val;
            bcnt  <= '0;
        end else if (shift) begin
            shreg <= {shreg[ADDR_W-2:0], 1'b0};
            bcnt  <= last ? '0 : bcnt + CW'(1);
        end
    end
endmodule

// File: rtl/vsf_sample_deser.sv
// Module: sample assembler. Collects captured bits, first bit into the
// top position, and emits a word plus a one-cycle strobe every
// SAMPLE_W bits.
// Assumes: clear is held while no read phase is active.
module vsf_sample_deser #(
    parameter int SAMPLE_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic                bit_in,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld
);
    localparam int CW = $clog2(SAMPLE_W);

    logic [SAMPLE_W-2:0] shreg;
    logic [CW-1:0]       bcnt;
    logic                full;

    assign full = (bcnt == CW'(SAMPLE_W - 1));

    // Gather bits and publish the finished word with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bcnt       <= '0;
            sample     <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= 1'b0;
            if (clear) begin
                shreg <= '0;
                bcnt  <= '0;
            end else if (capture) begin
                shreg <= {shreg[SAMPLE_W-3:0], bit_in};
                if (full) begin
                    sample     <= {shreg, bit_in};
                    sample_vld <= 1'b1;
                    bcnt       <= '0;
                end else begin
                    bcnt <= bcnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/voice_serial_fetch.sv
// Module: serial voice memory fetch master (top). Accepts a request and
// start address, shifts the address out on the address clock, then reads
// a continuous bit stream with the read clock and delivers packed samples.
// Assumes: start_addr, half_cyc and float_idle stay stable while busy; the
// pad ring combines sd_out, sd_oe and sd_in into one bidirectional pin.
module voice_serial_fetch #(
    parameter int ADDR_W   = 24,
    parameter int SAMPLE_W = 5,
    parameter int DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [DIV_W-1:0]    half_cyc,
    input  logic                float_idle,
    input  logic                sd_in,
    output logic                aclk_o,
    output logic                rclk_o,
    output logic                sd_out,
    output logic                sd_oe,
    output logic                bus_oe,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld,
    output logic                busy
);
    import vsf_pkg::*;

    vsf_state_t state;
    logic       phase, rise_p, fall_p;
    logic       addr_msb, addr_last;
    logic       in_idle, in_addr, in_read;

    assign in_idle = (state == VSF_IDLE);
    assign in_addr = (state == VSF_ADDR);
    assign in_read = (state == VSF_READ);

    vsf_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!in_idle),
        .half_cyc (half_cyc),
        .phase    (phase),
        .rise_p   (rise_p),
        .fall_p   (fall_p)
    );

    vsf_addr_shifter #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_idle),
        .load_val (start_addr),
        .shift    (in_addr & fall_p),
        .msb      (addr_msb),
        .last     (addr_last)
    );

    vsf_sample_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!in_read),
        .capture    (in_read & rise_p & req),
        .bit_in     (sd_in),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    // Sequence idle -> address -> read, leaving to idle as soon as req drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= VSF_IDLE;
        end else begin
            unique case (state)
                VSF_IDLE: if (req) state <= VSF_ADDR;
                VSF_ADDR: begin
                    if (!req)                       state <= VSF_IDLE;
                    else if (fall_p && addr_last)   state <= VSF_READ;
                end
                VSF_READ: if (!req) state <= VSF_IDLE;
                default:  state <= VSF_IDLE;
            endcase
        end
    end

    // Pin drive: clocks gated by phase, data driven only in the address phase or a held idle bus.
    always_comb begin
        busy   = !in_idle;
        aclk_o = in_addr & phase;
        rclk_o = in_read & phase;
        sd_out = in_addr & addr_msb;
        sd_oe  = in_addr | (in_idle & !float_idle);
        bus_oe = busy | !float_idle;
    end
endmodule

// File: rtl/vsf_checker.sv
// Module: protocol checker bound to the fetch master. It watches only the
// top-level ports.
// Assumes: the clocks and reset of the bound instance.
module vsf_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic float_idle,
    input logic busy,
    input logic aclk_o,
    input logic rclk_o,
    input logic sd_out,
    input logic sd_oe,
    input logic bus_oe,
    input logic sample_vld
);
    // R9
    clocks_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(aclk_o && rclk_o));

    // R2
    addr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aclk_o |-> sd_oe);

    // R2
    addr_bit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aclk_o && $past(aclk_o)) |-> $stable(sd_out));

    // R4
    read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rclk_o |-> !sd_oe);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    // R6
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!busy && !sample_vld));

    // R7
    float_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && float_idle) |-> (!sd_oe && !bus_oe));

    // R8
    busy_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_oe);
endmodule

bind voice_serial_fetch vsf_checker u_vsf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .float_idle (float_idle),
    .busy       (busy),
    .aclk_o     (aclk_o),
    .rclk_o     (rclk_o),
    .sd_out     (sd_out),
    .sd_oe      (sd_oe),
    .bus_oe     (bus_oe),
    .sample_vld (sample_vld)
);

// File: tb/voice_serial_fetch_tb_top.sv
module voice_serial_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] start_addr = '0;
    logic [7:0]  half_cyc = 8'd1;
    logic        float_idle = 1'b0;
    logic        sd_in;
    logic        aclk_o, rclk_o, sd_out, sd_oe, bus_oe, sample_vld, busy;
    logic [4:0]  sample;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    voice_serial_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .start_addr(start_addr),
        .half_cyc(half_cyc), .float_idle(float_idle), .sd_in(sd_in),
        .aclk_o(aclk_o), .rclk_o(rclk_o), .sd_out(sd_out), .sd_oe(sd_oe),
        .bus_oe(bus_oe), .sample(sample), .sample_vld(sample_vld), .busy(busy)
    );

    // Memory model: bit-addressed content from a fixed function of the address.
    function automatic logic mem_bit(input logic [23:0] a);
        return a[0] ^ a[2] ^ a[5] ^ (a[1] & a[3]);
    endfunction

    function automatic logic [4:0] exp_sample(input logic [23:0] a, input int k);
        logic [4:0] s;
        for (int j = 0; j < 5; j++) s[4-j] = mem_bit(a + 24'(5*k + j));
        return s;
    endfunction

    logic [23:0] rx_addr = '0;
    int          rd_ptr  = 0;
    always @(posedge aclk_o) rx_addr = {rx_addr[22:0], sd_out};
    always @(negedge rclk_o) rd_ptr = rd_ptr + 1;
    assign sd_in = mem_bit(rx_addr + 24'(rd_ptr));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // start_addr(24) | half_cyc(8) | float_idle(1)
    localparam logic [32:0] VECS [0:3] = '{
        {24'h000000, 8'd1, 1'b0},
        {24'hA5C3F1, 8'd2, 1'b1},
        {24'hFFFFFE, 8'd0, 1'b0},
        {24'h123456, 8'd3, 1'b1}
    };

    task automatic idle_check(input string tag);
        if (float_idle)
            chk(!sd_oe && !bus_oe, tag, {sd_oe, bus_oe}, 0);
        else
            chk(bus_oe && sd_oe && !sd_out && !aclk_o && !rclk_o, tag,
                {bus_oe, sd_oe, sd_out, aclk_o, rclk_o}, 5'b11000);
    endtask

    task automatic wait_vld(output bit seen);
        int to = 0;
        while (!sample_vld && to < 5000) begin @(negedge clk); to++; end
        seen = sample_vld;
    endtask

    task automatic run_vec(input logic [32:0] v);
        logic [23:0] a;
        int n, c, hi, to, extra;
        bit seen;
        a = v[32:9];
        n = (v[8:1] == 0) ? 1 : int'(v[8:1]);
        @(negedge clk);
        start_addr = a; half_cyc = v[8:1]; float_idle = v[0];
        @(negedge clk);
        idle_check("R7 idle bus");
        rd_ptr = 0;
        req = 1'b1;
        c = cyc;
        to = 0;
        do begin @(negedge clk); to++; end while (!aclk_o && to < 1000);
        chk(cyc - c == n + 1, "R3 first address clock rise", cyc - c, n + 1);
        hi = 0;
        while (aclk_o && hi < 1000) begin hi++; @(negedge clk); end
        chk(hi == n, "R3 high phase length", hi, n);
        wait_vld(seen);
        chk(seen && (cyc - c == 57*n + 1), "R5 first strobe latency", cyc - c, 57*n + 1);
        chk(rx_addr == a, "R2 address received", int'(rx_addr), int'(a));
        chk(!sd_oe && busy && bus_oe, "R4 R8 data released while reading", {sd_oe, busy, bus_oe}, 3'b011);
        chk(sample == exp_sample(a, 0), "R5 sample 0", sample, exp_sample(a, 0));
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            c = cyc;
            wait_vld(seen);
            chk(seen && (cyc - c == 10*n - 1), "R6 strobe spacing", cyc - c, 10*n - 1);
            chk(sample == exp_sample(a, k), "R6 continued sample", sample, exp_sample(a, k));
        end
        repeat (3*n) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(!busy && !aclk_o && !rclk_o, "R6 drop to idle", {busy, aclk_o, rclk_o}, 0);
        extra = 0;
        for (int i = 0; i < 12*n; i++) begin
            @(negedge clk);
            if (sample_vld || rclk_o) extra++;
        end
        chk(extra == 0, "R6 no activity after drop", extra, 0);
        idle_check("R7 idle after transfer");
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int act;
        repeat (4) @(negedge clk);
        chk(!busy && !aclk_o && !rclk_o && !sample_vld, "R1 reset state",
            {busy, aclk_o, rclk_o, sample_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 idle after reset release", busy, 0);

        for (int v = 0; v < 4; v++) run_vec(VECS[v]);

        // Abort in the middle of the address phase.
        @(negedge clk);
        start_addr = 24'h0F0F0F; half_cyc = 8'd2; float_idle = 1'b1;
        req = 1'b1;
        repeat (20) @(negedge clk);
        chk(busy && bus_oe && !rclk_o, "R8 busy during address", {busy, bus_oe, rclk_o}, 3'b110);
        req = 1'b0;
        @(negedge clk);
        chk(!busy && !sd_oe && !bus_oe, "R6 R7 abort floats bus", {busy, sd_oe, bus_oe}, 0);
        act = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (aclk_o || rclk_o || sample_vld) act++;
        end
        chk(act == 0, "R6 quiet after abort", act, 0);

        // A fresh transfer after the abort starts cleanly.
        run_vec({24'h0F0F0F, 8'd2, 1'b0});

        // Reset in the middle of the read phase.
        @(negedge clk);
        req = 1'b1;
        repeat (80) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !aclk_o && !rclk_o && !sample_vld, "R1 reset while busy",
            {busy, aclk_o, rclk_o, sample_vld}, 0);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule